// File: doc/BRIEF.md
# Output Compare Match Flag Unit

This block sits beside a timer counter and watches the running count against a programmable compare value of the same width. Equality is reported at once as a raw match pulse, which a waveform generator downstream uses together with the counter's top and bottom indications. The unit passes those two indications through unchanged so that the generator sees all three signals from one place.

Equality by itself does not set the compare flag. The flag is set by the timer tick that ends a cycle in which the count and the compare value were equal. The flag then stays set until it is cleared. It clears when the interrupt it raised is acknowledged, or when software writes a one to it. A write of zero leaves it as it was. The interrupt request is the flag gated by a local enable and a global enable. If a set and a clear fall in the same cycle, the set wins, so no match event is lost.

Top module: `ocmp_flag_unit`

## Requirements
- R1: `matchOut` is 1 in exactly those cycles where all bits of `count` equal all bits of `cmpVal`. It is combinational and does not depend on `tick`.
- R2: `topOut` equals `topIn` and `bottomOut` equals `bottomIn` in every cycle.
- R3: A rising clock edge with `tick`=1 and `count`==`cmpVal` makes `cmpFlag` 1 from the next cycle.
- R4: With `tick`=0, `cmpFlag` is not set, even while `count` equals `cmpVal`.
- R5: `irqReq` is 1 exactly when `cmpFlag`, `localIrqEn` and `globalIrqEn` are all 1.
- R6: A clock edge with `irqAck`=1 clears `cmpFlag` from the next cycle, unless R8 applies.
- R7: A clock edge with `flagWrEn`=1 and `flagWrData`=1 clears `cmpFlag`. With `flagWrData`=0 the flag keeps its value.
- R8: When a set (R3) and a clear (R6 or R7) happen at the same edge, `cmpFlag` becomes 1.
- R9: While `rstN` is 0, `cmpFlag` and `irqReq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timer tick qualifier, one cycle wide |
| count | input | 8 | Running count from the counter |
| cmpVal | input | 8 | Compare register value |
| topIn | input | 1 | Counter at its top value |
| bottomIn | input | 1 | Counter at zero |
| localIrqEn | input | 1 | Compare interrupt enable |
| globalIrqEn | input | 1 | Global interrupt enable |
| irqAck | input | 1 | Interrupt acknowledge, clears the flag |
| flagWrEn | input | 1 | Software write strobe for the flag bit |
| flagWrData | input | 1 | Data written; 1 clears, 0 has no effect |
| matchOut | output | 1 | Raw equality pulse for the waveform generator |
| topOut | output | 1 | Pass-through of topIn |
| bottomOut | output | 1 | Pass-through of bottomIn |
| cmpFlag | output | 1 | Compare flag |
| irqReq | output | 1 | Gated interrupt request |

## Verification
The bench holds the count equal to the compare value with no tick. A design that sets the flag on equality alone would raise it there. It drives an acknowledge and a write-one in the same edge as a tick on a match. A design that lets the clear win would drop that event. It writes zero to a set flag, which a careless decode would treat as a clear. It also walks all four enable combinations and compares values that differ in a single bit, which exposes a comparator that misses a bit or a gate that ignores one enable.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int CNT_W = 8;

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
  } ocStrobe_t;
endpackage

// File: rtl/ocmp_datapath.sv
module ocmp_datapath
  import ocmp_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmpVal,
  input  logic         topIn,
  input  logic         bottomIn,
  input  ocStrobe_t    strobe,
  output logic         match,
  output logic         topOut,
  output logic         bottomOut,
  output logic         flagQ
);
  logic [W-1:0] bitEq;

  // per-bit equality, reduced below
  for (genvar i = 0; i < W; i++) begin : g_eq
    assign bitEq[i] = ~(count[i] ^ cmpVal[i]);
  end

  assign match     = &bitEq;
  assign topOut    = topIn;
  assign bottomOut = bottomIn;

  // set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               flagQ <= 1'b0;
    else if (strobe.setFlag) flagQ <= 1'b1;
    else if (strobe.clrFlag) flagQ <= 1'b0;
  end

  AST_FLAG_RESET: assert property (@(posedge clk) !rstN |=> !flagQ); // R9
endmodule

// File: rtl/ocmp_control.sv
module ocmp_control
  import ocmp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      match,
  input  logic      flagQ,
  input  logic      localIrqEn,
  input  logic      globalIrqEn,
  input  logic      irqAck,
  input  logic      flagWrEn,
  input  logic      flagWrData,
  output ocStrobe_t strobe,
  output logic      irqReq
);
  logic swClear;

  assign swClear        = flagWrEn & flagWrData;
  assign strobe.setFlag = tick & match;
  assign strobe.clrFlag = irqAck | swClear;
  assign irqReq         = flagQ & localIrqEn & globalIrqEn;

  AST_SET_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (tick && match) |=> flagQ); // R3
  AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !flagQ) |=> !flagQ); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !(tick && match)) |=> !flagQ); // R6
  AST_WR0_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !irqAck && !(flagWrEn && flagWrData)) |=> flagQ); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (tick && match && (irqAck || swClear)) |=> flagQ); // R8
endmodule

// File: rtl/ocmp_flag_unit.sv
module ocmp_flag_unit
  import ocmp_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmpVal,
  input  logic         topIn,
  input  logic         bottomIn,
  input  logic         localIrqEn,
  input  logic         globalIrqEn,
  input  logic         irqAck,
  input  logic         flagWrEn,
  input  logic         flagWrData,
  output logic         matchOut,
  output logic         topOut,
  output logic         bottomOut,
  output logic         cmpFlag,
  output logic         irqReq
);
  ocStrobe_t strobe;

  ocmp_datapath #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .count(count), .cmpVal(cmpVal),
    .topIn(topIn), .bottomIn(bottomIn), .strobe(strobe),
    .match(matchOut), .topOut(topOut), .bottomOut(bottomOut),
    .flagQ(cmpFlag)
  );

  ocmp_control ctl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .match(matchOut),
    .flagQ(cmpFlag), .localIrqEn(localIrqEn), .globalIrqEn(globalIrqEn),
    .irqAck(irqAck), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .strobe(strobe), .irqReq(irqReq)
  );
endmodule

// File: tb/ocmp_flag_unit_tb.sv
module ocmp_flag_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, topIn = 1'b0, bottomIn = 1'b0;
  logic localIrqEn = 1'b0, globalIrqEn = 1'b0, irqAck = 1'b0;
  logic flagWrEn = 1'b0, flagWrData = 1'b0;
  logic [7:0] count = 8'd0, cmpVal = 8'd0;
  logic matchOut, topOut, bottomOut, cmpFlag, irqReq;

  int checks = 0, fails = 0;
  bit done = 0;
  bit modelFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocmp_flag_unit dut_i (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle at a negedge, check outputs, then advance the model at the edge
  task automatic step(input bit t, input logic [7:0] c, input logic [7:0] v,
                      input bit le, input bit ge, input bit ack,
                      input bit we, input bit wd, input string tag);
    tick = t; count = c; cmpVal = v; localIrqEn = le; globalIrqEn = ge;
    irqAck = ack; flagWrEn = we; flagWrData = wd;
    topIn = c[0]; bottomIn = c[1];
    #1;
    check(cmpFlag == modelFlag, {tag, " flag"}, cmpFlag, modelFlag);
    check(matchOut == (c == v), "R1 match", matchOut, (c == v));
    check(topOut == topIn && bottomOut == bottomIn, "R2 passthru",
          {topOut, bottomOut}, {topIn, bottomIn});
    check(irqReq == (modelFlag && le && ge), "R5 irq", irqReq, modelFlag && le && ge);
    @(posedge clk);
    if (t && c == v) modelFlag = 1;
    else if (ack || (we && wd)) modelFlag = 0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    count = 8'h55; cmpVal = 8'h55; tick = 1'b1; localIrqEn = 1; globalIrqEn = 1;
    repeat (3) @(negedge clk);
    check(cmpFlag == 0 && irqReq == 0, "R9 reset", {cmpFlag, irqReq}, 0);
    rstN = 1'b1;
    tick = 1'b0;
    @(negedge clk);
    // R4: equal but no tick
    repeat (4) step(0, 8'h3C, 8'h3C, 1, 1, 0, 0, 0, "R4");
    // R3: tick on match
    step(1, 8'h3C, 8'h3C, 1, 1, 0, 0, 0, "R3");
    step(0, 8'h3D, 8'h3C, 1, 1, 0, 0, 0, "R3");
    // R5: enable combinations
    step(0, 8'h3D, 8'h3C, 0, 1, 0, 0, 0, "R5");
    step(0, 8'h3D, 8'h3C, 1, 0, 0, 0, 0, "R5");
    step(0, 8'h3D, 8'h3C, 0, 0, 0, 0, 0, "R5");
    // R7: write zero keeps, write one clears
    step(0, 8'h3D, 8'h3C, 1, 1, 0, 1, 0, "R7");
    step(0, 8'h3D, 8'h3C, 1, 1, 0, 1, 1, "R7");
    step(0, 8'h3D, 8'h3C, 1, 1, 0, 0, 0, "R7");
    // R6: ack clears
    step(1, 8'h80, 8'h80, 1, 1, 0, 0, 0, "R6");
    step(0, 8'h81, 8'h80, 1, 1, 1, 0, 0, "R6");
    step(0, 8'h81, 8'h80, 1, 1, 0, 0, 0, "R6");
    // R8: set beats ack and write-one at the same edge
    step(1, 8'hFF, 8'hFF, 1, 1, 1, 0, 0, "R8");
    step(1, 8'h00, 8'h00, 1, 1, 0, 1, 1, "R8");
    step(1, 8'h01, 8'h00, 1, 1, 1, 1, 1, "R8");
    step(0, 8'h01, 8'h00, 1, 1, 0, 0, 0, "R8");
    // R1: single-bit differences
    for (int b = 0; b < 8; b++) step(1, 8'hA5 ^ (8'd1 << b), 8'hA5, 1, 1, 0, 0, 0, "R1");
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0] c;
      logic [7:0] v;
      c = 8'($urandom_range(0, 7));
      v = 8'($urandom_range(0, 7));
      step(1'($urandom_range(0, 1)), c, v, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 4) == 0), 1'($urandom_range(0, 1)), "R3 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule